// File: doc/BRIEF.md
# Frame Viterbi Decoder (hard decision, K=7, rate 1/2)

This block recovers a message from a rate-1/2 convolutional code with constraint length 7, one frame at a time. Each received code pair is presented with a valid/ready handshake and tagged with frame-begin and frame-end flags. For every pair the block forms Hamming branch metrics and runs add-compare-select over all 64 trellis states, one state per clock. It also stores one survivor decision bit per state per stage.

When the frame-end pair has been processed, the block picks the state with the smallest accumulated metric and walks the stored decisions backwards. The recovered bits are written into a reversal buffer and sent out first-bit-first on a valid/ready output with a last marker. Frames are decoded as a whole. A frame longer than the survivor store is cut at the store depth and flagged.

Top module: `vit_frame_dec`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `frame_err` is 0.
- R2: The trellis state is the last six message bits with the newest in bit 0, so the next state is `{state[4:0], bit}`. The bit sent first in each pair (`in_sym[1]`) is the parity of the 7-bit window against generator A (default octal 171), and `in_sym[0]` uses generator B (default octal 133). A generator's MSB taps the newest bit. An error-free frame that starts from state 0 decodes to its exact message, for every 7-bit message.
- R3: Branch metrics are Hamming distances (0 to 2). Each state keeps the smaller of its two candidate sums, and on a tie it keeps the predecessor whose dropped bit is 0.
- R4: An accepted pair keeps `in_ready` low for exactly 64 cycles: it is high again at the 64th rising edge after the accepting edge.
- R5: A pair accepted with `in_first` starts a new frame. State 0 starts at metric 0 and all other states start high, and `frame_err` clears.
- R6: A single flipped code bit in any pair other than the last of the frame is corrected, both in 7-bit frames and in 64-bit frames.
- R7: Traceback starts at the state with the smallest final metric, and the lowest state index wins a tie. So a single flipped bit in the final pair returns the other message bits intact and a final bit of 0.
- R8: Decoded bits leave oldest first, with `out_last` on the final bit only. The first `out_valid` comes 64+L cycles after the frame-end pair is accepted, where L is the number of stored stages. After the last transfer the block is idle again.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_last` hold.
- R10: Pairs beyond 64 stages are accepted with no busy time and discarded, and `frame_err` is set and stays set until the next `in_first` pair. The output is then the first 64 decoded bits.
- R11: Path metrics are renormalised each stage by subtracting the previous minimum, so the stored minimum never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Code pair offered |
| in_ready | output | 1 | Block can take a code pair |
| in_sym | input | 2 | Received pair, bit 1 sent first |
| in_first | input | 1 | Pair is the first of a frame |
| in_last | input | 1 | Pair is the last of a frame |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Consumer takes the bit |
| out_bit | output | 1 | Decoded message bit |
| out_last | output | 1 | Final bit of the frame |
| frame_err | output | 1 | Frame exceeded the survivor depth |

## Verification
Each accepted pair is due back as `in_ready` high at the 64th edge after acceptance, and a discarded overflow pair at the accepting edge itself. The bench reads the cycle counter at the first falling edge where `in_ready` is high and compares it with these figures. The first decoded bit is due 64+L edges after the frame-end pair (L edges for a discarded frame-end pair). The bench samples `out_valid` on falling edges and checks the counter difference exactly. Under output back-pressure the held values are compared one cycle later, and decoded frames are compared bit-for-bit with messages the bench encodes itself.

// File: rtl/vit_pkg.sv
package vit_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ACS   = 2'd1,
      PH_TRACE = 2'd2,
      PH_SEND  = 2'd3
   } vit_phase_e;

   // Hamming distance between two 2-bit code pairs
   function automatic logic [1:0] vit_ham2(input logic [1:0] a, input logic [1:0] b);
      logic [1:0] x;
      x = a ^ b;
      return {1'b0, x[1]} + {1'b0, x[0]};
   endfunction

endpackage

// File: rtl/vit_acs.sv
module vit_acs import vit_pkg::*; #(
   parameter int       K       = 7,
   parameter int       PM_W    = 8,
   parameter logic [K-1:0] G_A = 7'o171,
   parameter logic [K-1:0] G_B = 7'o133,
   parameter bit       A_FIRST = 1'b1
) (
   input  logic [K-2:0]    nxt,
   input  logic [1:0]      sym,
   input  logic [PM_W-1:0] pm_p0,
   input  logic [PM_W-1:0] pm_p1,
   input  logic [PM_W-1:0] pm_floor,
   output logic [PM_W-1:0] pm_new,
   output logic            dec
);
   localparam int M = K - 1;

   logic [K-1:0]  win0, win1;
   logic          pa0, pb0, pa1, pb1;
   logic [1:0]    exp0, exp1;
   logic [PM_W:0] sum0, sum1;
   logic [PM_W-1:0] c0, c1;

   // window: bit 0 = newest input, bit i = input i steps back
   assign win0 = {1'b0, nxt[M-1:1], nxt[0]};
   assign win1 = {1'b1, nxt[M-1:1], nxt[0]};

   always_comb begin
      pa0 = 1'b0; pb0 = 1'b0; pa1 = 1'b0; pb1 = 1'b0;
      for (int i = 0; i < K; i++) begin
         pa0 = pa0 ^ (win0[i] & G_A[K-1-i]);
         pb0 = pb0 ^ (win0[i] & G_B[K-1-i]);
         pa1 = pa1 ^ (win1[i] & G_A[K-1-i]);
         pb1 = pb1 ^ (win1[i] & G_B[K-1-i]);
      end
   end

   generate
      if (A_FIRST) begin : g_a_first
         assign exp0 = {pa0, pb0};
         assign exp1 = {pa1, pb1};
      end else begin : g_b_first
         assign exp0 = {pb0, pa0};
         assign exp1 = {pb1, pa1};
      end
   endgenerate

   // R3: add, compare, select with saturation; ties keep predecessor 0
   assign sum0 = {1'b0, pm_p0 - pm_floor} + {{(PM_W-1){1'b0}}, vit_ham2(exp0, sym)};
   assign sum1 = {1'b0, pm_p1 - pm_floor} + {{(PM_W-1){1'b0}}, vit_ham2(exp1, sym)};
   assign c0   = sum0[PM_W] ? {PM_W{1'b1}} : sum0[PM_W-1:0];
   assign c1   = sum1[PM_W] ? {PM_W{1'b1}} : sum1[PM_W-1:0];
   assign dec    = (c1 < c0);
   assign pm_new = dec ? c1 : c0;

endmodule

// File: rtl/vit_surv_mem.sv
module vit_surv_mem #(
   parameter int NS    = 64,
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH),
   parameter int SW    = $clog2(NS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [SW-1:0] wcol,
   input  logic          wbit,
   input  logic [AW-1:0] raddr,
   input  logic [SW-1:0] rcol,
   output logic          rbit
);
   logic [NS-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr][wcol] <= wbit;
   end

   assign rbit = mem_q[raddr][rcol];

endmodule

// File: rtl/vit_rev_buf.sv
module vit_rev_buf #(
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wbit,
   input  logic [AW-1:0] raddr,
   output logic          rbit
);
   logic [DEPTH-1:0] bits_q;

   always_ff @(posedge clk) begin
      if (we) bits_q[waddr] <= wbit;
   end

   assign rbit = bits_q[raddr];

endmodule

// File: rtl/vit_frame_dec.sv
module vit_frame_dec import vit_pkg::*; #(
   parameter int           K       = 7,
   parameter int           PM_W    = 8,
   parameter int           MAX_LEN = 64,
   parameter logic [K-1:0] G_A     = 7'o171,
   parameter logic [K-1:0] G_B     = 7'o133,
   parameter bit           A_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [1:0] in_sym,
   input  logic       in_first,
   input  logic       in_last,
   output logic       out_valid,
   input  logic       out_ready,
   output logic       out_bit,
   output logic       out_last,
   output logic       frame_err
);
   localparam int M  = K - 1;
   localparam int NS = 1 << M;
   localparam int AW = $clog2(MAX_LEN);
   localparam int LW = $clog2(MAX_LEN + 1);
   localparam logic [PM_W-1:0] INIT_PM = PM_W'((1 << (PM_W - 1)) - 1);

   generate
      if (K < 3 || K > 16) begin : g_bad_k
         $error("vit_frame_dec: K must lie in 3..16");
      end
      if (PM_W < 4) begin : g_bad_pmw
         $error("vit_frame_dec: PM_W must be at least 4");
      end
      if (MAX_LEN < 2 || NS * MAX_LEN > 8192) begin : g_bad_len
         $error("vit_frame_dec: survivor store size out of range");
      end
   endgenerate

   vit_phase_e      phase_q;
   logic [M-1:0]    st_cnt_q;
   logic [LW-1:0]   cnt_q;
   logic            fresh_q;
   logic            bank_q;
   logic [PM_W-1:0] pm_floor;
   logic [PM_W-1:0] run_min_q;
   logic [M-1:0]    run_best_q;
   logic [1:0]      sym_q;
   logic            last_q;
   logic            err_q;
   logic [M-1:0]    tb_state_q;
   logic [AW-1:0]   tb_idx_q;
   logic [AW-1:0]   out_idx_q;
   logic [PM_W-1:0] pm_q [2][NS];

   logic [M-1:0]    pred0, pred1;
   logic [PM_W-1:0] old0, old1, pm_new, cmin;
   logic [M-1:0]    cbest;
   logic            dec, surv_bit, acs_end;
   logic [LW-1:0]   cnt_eff;
   logic            full;

   assign in_ready  = (phase_q == PH_IDLE);
   assign out_valid = (phase_q == PH_SEND);
   assign out_last  = out_valid && ((LW'(out_idx_q) + LW'(1)) == cnt_q);
   assign frame_err = err_q;

   assign pred0 = {1'b0, st_cnt_q[M-1:1]};
   assign pred1 = {1'b1, st_cnt_q[M-1:1]};

   // R5: a fresh frame reads state 0 as metric 0 and every other state as INIT_PM
   always_comb begin
      if (fresh_q) begin
         old0 = (pred0 == '0) ? '0 : INIT_PM;
         old1 = INIT_PM;
      end else begin
         old0 = pm_q[bank_q][pred0];
         old1 = pm_q[bank_q][pred1];
      end
   end

   vit_acs #(
      .K(K), .PM_W(PM_W), .G_A(G_A), .G_B(G_B), .A_FIRST(A_FIRST)
   ) u_acs (
      .nxt(st_cnt_q), .sym(sym_q), .pm_p0(old0), .pm_p1(old1),
      .pm_floor(pm_floor), .pm_new(pm_new), .dec(dec)
   );

   // R7: running minimum over the stage, strict compare keeps the lowest index
   always_comb begin
      if (st_cnt_q == '0 || pm_new < run_min_q) begin
         cmin  = pm_new;
         cbest = st_cnt_q;
      end else begin
         cmin  = run_min_q;
         cbest = run_best_q;
      end
   end

   assign acs_end = (phase_q == PH_ACS) && (st_cnt_q == M'(NS - 1));
   assign cnt_eff = in_first ? '0 : cnt_q;
   assign full    = (cnt_eff == LW'(MAX_LEN));

   vit_surv_mem #(.NS(NS), .DEPTH(MAX_LEN), .AW(AW), .SW(M)) u_surv (
      .clk(clk), .we(phase_q == PH_ACS), .waddr(cnt_q[AW-1:0]), .wcol(st_cnt_q),
      .wbit(dec), .raddr(tb_idx_q), .rcol(tb_state_q), .rbit(surv_bit)
   );

   vit_rev_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_rev (
      .clk(clk), .we(phase_q == PH_TRACE), .waddr(tb_idx_q), .wbit(tb_state_q[0]),
      .raddr(out_idx_q), .rbit(out_bit)
   );

   // double-buffered path metrics: ACS writes the bank not being read
   always_ff @(posedge clk) begin
      if (phase_q == PH_ACS) pm_q[~bank_q][st_cnt_q] <= pm_new;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         st_cnt_q   <= '0;
         cnt_q      <= '0;
         fresh_q    <= 1'b1;
         bank_q     <= 1'b0;
         pm_floor   <= '0;
         run_min_q  <= '0;
         run_best_q <= '0;
         sym_q      <= '0;
         last_q     <= 1'b0;
         err_q      <= 1'b0;
         tb_state_q <= '0;
         tb_idx_q   <= '0;
         out_idx_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (in_valid) begin
                  if (in_first) begin
                     cnt_q    <= '0;
                     fresh_q  <= 1'b1;
                     pm_floor <= '0;
                     err_q    <= 1'b0;
                  end
                  if (full) begin
                     // R10: pair beyond the store is dropped and flagged
                     err_q <= 1'b1;
                     if (in_last) begin
                        tb_state_q <= run_best_q;
                        tb_idx_q   <= AW'(cnt_q - LW'(1));
                        phase_q    <= PH_TRACE;
                     end
                  end else begin
                     sym_q    <= in_sym;
                     last_q   <= in_last;
                     st_cnt_q <= '0;
                     phase_q  <= PH_ACS;
                  end
               end
            end
            PH_ACS: begin
               run_min_q  <= cmin;
               run_best_q <= cbest;
               st_cnt_q   <= st_cnt_q + M'(1);
               if (acs_end) begin
                  bank_q   <= ~bank_q;
                  pm_floor <= cmin;
                  fresh_q  <= 1'b0;
                  cnt_q    <= cnt_q + LW'(1);
                  if (last_q) begin
                     tb_state_q <= cbest;
                     tb_idx_q   <= cnt_q[AW-1:0];
                     phase_q    <= PH_TRACE;
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end
            end
            PH_TRACE: begin
               tb_state_q <= {surv_bit, tb_state_q[M-1:1]};
               if (tb_idx_q == '0) begin
                  out_idx_q <= '0;
                  phase_q   <= PH_SEND;
               end else begin
                  tb_idx_q <= tb_idx_q - AW'(1);
               end
            end
            PH_SEND: begin
               if (out_ready) begin
                  if (out_last) phase_q <= PH_IDLE;
                  else          out_idx_q <= out_idx_q + AW'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vit_frame_dec_chk.sv
module vit_frame_dec_chk #(
   parameter int PM_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            in_first,
   input logic            out_valid,
   input logic            out_ready,
   input logic            out_bit,
   input logic            out_last,
   input logic            frame_err,
   input logic [PM_W-1:0] pm_floor
);

   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (in_ready && !out_valid && !frame_err));

   a_r4_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_valid);

   a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

   a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_last)));

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err && !(in_valid && in_ready && in_first)) |=> frame_err);

   a_r11_floor_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pm_floor <= PM_W'(2));

endmodule

bind vit_frame_dec vit_frame_dec_chk #(.PM_W(PM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_first(in_first), .out_valid(out_valid), .out_ready(out_ready),
   .out_bit(out_bit), .out_last(out_last), .frame_err(frame_err),
   .pm_floor(pm_floor)
);

// File: tb/vit_frame_dec_tb.sv
`timescale 1ns/1ps
module vit_frame_dec_tb;
   localparam int NS   = 64;
   localparam int MAXL = 64;
   localparam logic [6:0] GA = 7'o171;
   localparam logic [6:0] GB = 7'o133;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, out_ready = 1'b0;
   logic [1:0] in_sym = 2'b00;
   logic in_ready, out_valid, out_bit, out_last, frame_err;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [1:0] tx [72];
   logic       msg [72];
   logic       expb [64];
   logic       got [64];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   vit_frame_dec u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sym(in_sym), .in_first(in_first), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
      .out_last(out_last), .frame_err(frame_err)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference encoder: newest bit at window bit 0, generator MSB taps it
   task automatic encode(input int n);
      logic [5:0] st;
      st = '0;
      for (int i = 0; i < n; i++) begin
         logic [6:0] w;
         logic a, b;
         w = {st, msg[i]};
         a = 1'b0; b = 1'b0;
         for (int j = 0; j < 7; j++) begin
            a = a ^ (w[j] & GA[6-j]);
            b = b ^ (w[j] & GB[6-j]);
         end
         tx[i] = {a, b};
         st = {st[4:0], msg[i]};
      end
   endtask

   task automatic flip(input int f);
      tx[f/2] = tx[f/2] ^ ((f % 2 == 0) ? 2'b10 : 2'b01);
   endtask

   task automatic run_frame(input int nsym, input int nexp, input int drop, input int lat,
                            input bit stall, input string req);
      int last_acc, k, mism;
      bit first_seen, held;
      logic pb, pl;
      last_acc = 0;
      for (int i = 0; i < nsym; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sym = tx[i];
         in_first = (i == 0); in_last = (i == nsym - 1);
         while (!in_ready) @(negedge clk);
         @(posedge clk); #1;
         last_acc = cyc;
         @(negedge clk);
         in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
         if (i < nsym - 1) begin
            while (!in_ready) @(negedge clk);
            if (i >= drop)
               chk(cyc - last_acc == 0, "R10", "busy cycles for dropped pair", cyc - last_acc, 0);
            else
               chk(cyc - last_acc == NS, "R4", "busy cycles per pair", cyc - last_acc, NS);
         end
      end
      k = 0; first_seen = 1'b0; held = 1'b0; pb = 1'b0; pl = 1'b0;
      while (k < nexp) begin
         if (held) begin
            chk(out_valid && out_bit == pb && out_last == pl, "R9", "output held under stall",
                {out_valid, out_bit, out_last}, {1'b1, pb, pl});
            held = 1'b0;
         end
         out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
         if (out_valid) begin
            if (!first_seen) begin
               chk(cyc - last_acc == lat, "R8", "first output latency", cyc - last_acc, lat);
               first_seen = 1'b1;
            end
            if (out_ready) begin
               got[k] = out_bit;
               chk(out_last == (k == nexp - 1), "R8", "last flag position", out_last, k == nexp - 1);
               k++;
            end else begin
               held = 1'b1; pb = out_bit; pl = out_last;
            end
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(in_ready && !out_valid, "R8", "idle after last bit", {in_ready, out_valid}, 2'b10);
      mism = 0;
      for (int j = 0; j < nexp; j++) if (got[j] !== expb[j]) mism++;
      chk(mism == 0, req, "decoded bit mismatches", mism, 0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int vals [6];
      vals = '{0, 127, 85, 42, 75, 19};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(frame_err == 1'b0, "R1", "frame_err after reset", frame_err, 0);

      // R2: every 7-bit message, error free
      for (int v = 0; v < 128; v++) begin
         for (int i = 0; i < 7; i++) begin
            msg[i] = v[6-i];
            expb[i] = v[6-i];
         end
         encode(7);
         run_frame(7, 7, 7, NS + 7, 1'b0, "R2");
      end

      // R3/R6/R7: single flipped code bit in 7-bit frames
      for (int m = 0; m < 6; m++) begin
         for (int f = 0; f < 14; f++) begin
            for (int i = 0; i < 7; i++) begin
               msg[i] = vals[m][6-i];
               expb[i] = vals[m][6-i];
            end
            encode(7);
            flip(f);
            if (f >= 12) begin
               expb[6] = 1'b0;
               run_frame(7, 7, 7, NS + 7, 1'b0, "R7");
            end else begin
               run_frame(7, 7, 7, NS + 7, 1'b0, "R3/R6");
            end
         end
      end

      // R11/R9: full-depth frame, clean, with output stalls
      for (int i = 0; i < 64; i++) begin
         msg[i] = ((i * i * 7 + i * 3 + 1) % 5) > 2;
         expb[i] = msg[i];
      end
      encode(64);
      run_frame(64, 64, 64, NS + 64, 1'b1, "R11");
      chk(frame_err == 1'b0, "R10", "no error for full-depth frame", frame_err, 0);

      // R6: full-depth frame with one flip mid-frame
      encode(64);
      flip(41);
      run_frame(64, 64, 64, NS + 64, 1'b0, "R6");

      // R10: frame of 66 pairs, extra pairs dropped
      encode(64);
      tx[64] = 2'b00;
      tx[65] = 2'b11;
      run_frame(66, 64, 64, 64, 1'b0, "R10");
      chk(frame_err == 1'b1, "R10", "error flag after long frame", frame_err, 1);

      // R5: new frame clears the flag and restarts metrics
      for (int i = 0; i < 7; i++) begin
         msg[i] = (i % 3) == 1;
         expb[i] = msg[i];
      end
      encode(7);
      run_frame(7, 7, 7, NS + 7, 1'b0, "R5");
      chk(frame_err == 1'b0, "R5", "error flag cleared by new frame", frame_err, 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule